// File: doc/BRIEF.md
# Packet Store with Readback Symbol Corruption

This block stands in for a storage device on a link that carries 16-bit words made of two 8-bit symbols, each symbol with its own control-character flag. A receive state machine watches the incoming word stream, picks out packets that open with a start marker and close with an end marker, and writes those words into an internal FIFO. Idle comma words, whether between packets or inside one, are discarded.

A transmit state machine replays the stored words in order, one per cycle, for as long as the send input is high. When send is low or nothing is stored it emits idle comma words. On the way out a corruption stage can XOR a mask into one chosen data symbol of every 255-symbol block, so that a downstream block decoder sees a controlled error pattern. Control symbols are never altered. If the FIFO fills during reception, the rest of that packet is thrown away and a sticky overflow flag is raised.

Symbol order: the low byte `[7:0]` is the first symbol of a word, flag bit 0 belongs to it; the high byte `[15:8]` is the second, flag bit 1 belongs to it.

Top module: `ser_store`

## Requirements
- R1: After reset the output word is 0xBCBC with both flags set (1 1), and the overflow flag is 0.
- R2: Outside a packet, every word other than a start word is ignored and never stored; the start word is a word whose low byte is 0xFB with flag bit 0 set.
- R3: A packet is stored from its start word up to and including its end word (low byte 0xFD with flag bit 0 set) and replayed in arrival order, one word per cycle, data and flags together.
- R4: A comma idle word (data 0xBCBC, flags 1 1) that arrives inside a packet is dropped and does not end the packet.
- R5: When send is low at a clock edge, or the FIFO is empty at that edge, the output after that edge is the comma idle word.
- R6: Dropping send pauses replay without losing a word; raising it again continues from the next stored word.
- R7: With corruption enabled, the data symbol whose index equals the configured index is XORed with the mask; indices count only data symbols (flag 0), start at 0 on the word after a start word, run low byte before high byte, and wrap from 254 to 0.
- R8: A symbol flagged as a control character is output unchanged, whatever the corruption settings; the start word is never altered.
- R9: With corruption disabled the replayed words equal the stored words.
- R10: When a word of a packet arrives with the FIFO full, it and the rest of that packet up to and including its end word are dropped, and the overflow flag goes to 1 and stays there until reset.
- R11: Once drained after an overflow, the store accepts and replays a new packet normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 16 | Incoming word, two symbols |
| rx_k_i | input | 2 | Control flag per incoming symbol |
| send_i | input | 1 | Replay enable |
| corr_en_i | input | 1 | Corruption enable |
| corr_idx_i | input | 8 | Data symbol index to corrupt within each block |
| corr_mask_i | input | 8 | XOR mask for the selected symbol |
| tx_data_o | output | 16 | Outgoing word |
| tx_k_o | output | 2 | Control flag per outgoing symbol |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
A received word is written at the clock edge that samples it, so it can be replayed at the very next edge; the overflow flag is registered at the edge that sees the first refused word and is read half a cycle later. The output word is registered at the edge that samples send, so each replayed or idle word is due one edge after send is applied. The bench changes inputs on the falling edge and reads outputs on the following falling edge, so every check sits exactly one rising edge after its stimulus. Corruption settings are held steady across a whole replay because they are applied at the edge a word leaves the FIFO.

// File: rtl/ser_store_pkg.sv
package ser_store_pkg;
  localparam int unsigned SYM_W = 8;
  localparam int unsigned LANES = 2;
  localparam int unsigned WORD_W = SYM_W * LANES;

  localparam logic [SYM_W-1:0] SYM_COMMA = 8'hBC;
  localparam logic [SYM_W-1:0] SYM_START = 8'hFB;
  localparam logic [SYM_W-1:0] SYM_END   = 8'hFD;

  typedef struct packed {
    logic [LANES-1:0]  k;
    logic [WORD_W-1:0] d;
  } word_t;

  localparam word_t IDLE_WORD = '{k: '1, d: {LANES{SYM_COMMA}}};

  typedef enum logic [1:0] {
    RX_WAIT,
    RX_STORE,
    RX_DISCARD
  } rx_state_e;

  function automatic logic is_start(word_t w);
    return w.k[0] && (w.d[SYM_W-1:0] == SYM_START);
  endfunction

  function automatic logic is_end(word_t w);
    return w.k[0] && (w.d[SYM_W-1:0] == SYM_END);
  endfunction

  function automatic logic is_idle(word_t w);
    return w == IDLE_WORD;
  endfunction
endpackage

// File: rtl/ser_store_fifo.sv
module ser_store_fifo #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign full_o  = (cnt == FULL_CNT);
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/ser_store_rx.sv
module ser_store_rx
  import ser_store_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  word_t rx_i,
  input  logic  full_i,
  output logic  push_o,
  output word_t wdata_o,
  output logic  ovf_o
);
  rx_state_e state_q, state_d;
  logic      ovf_set;

  assign wdata_o = rx_i;

  always_comb begin
    state_d = state_q;
    push_o  = 1'b0;
    ovf_set = 1'b0;
    unique case (state_q)
      RX_WAIT: begin
        if (is_start(rx_i)) begin
          if (full_i) begin
            ovf_set = 1'b1;
            state_d = RX_DISCARD;
          end else begin
            push_o  = 1'b1;
            state_d = RX_STORE;
          end
        end
      end
      RX_STORE: begin
        if (!is_idle(rx_i)) begin
          if (full_i) begin
            ovf_set = 1'b1;
            state_d = is_end(rx_i) ? RX_WAIT : RX_DISCARD;
          end else begin
            push_o = 1'b1;
            if (is_end(rx_i)) state_d = RX_WAIT;
          end
        end
      end
      RX_DISCARD: begin
        if (is_end(rx_i)) state_d = RX_WAIT;
      end
      default: state_d = RX_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_WAIT;
      ovf_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ovf_set) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ser_store_corrupt.sv
module ser_store_corrupt #(
  parameter int unsigned LANES = 2,
  parameter int unsigned SYM_W = 8,
  parameter int unsigned BLK   = 255,
  localparam int unsigned CW   = $clog2(BLK + 1)
) (
  input  logic [LANES*SYM_W-1:0] sym_i,
  input  logic [LANES-1:0]       k_i,
  input  logic [CW-1:0]          cnt_i,
  input  logic                   en_i,
  input  logic [CW-1:0]          idx_i,
  input  logic [SYM_W-1:0]       mask_i,
  output logic [LANES*SYM_W-1:0] sym_o,
  output logic [CW-1:0]          cnt_o
);
  localparam logic [CW-1:0] WRAP = CW'(BLK - 1);

  logic [CW-1:0] lane_idx [LANES];

  // data symbols advance the block position, control symbols do not
  always_comb begin
    logic [CW-1:0] c;
    c = cnt_i;
    for (int i = 0; i < LANES; i++) begin
      lane_idx[i] = c;
      if (!k_i[i]) c = (c == WRAP) ? '0 : c + CW'(1);
    end
    cnt_o = c;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    assign hit = en_i && !k_i[g] && (lane_idx[g] == idx_i);
    assign sym_o[g*SYM_W +: SYM_W] = sym_i[g*SYM_W +: SYM_W] ^ (hit ? mask_i : '0);
  end
endmodule

// File: rtl/ser_store_tx.sv
module ser_store_tx
  import ser_store_pkg::*;
#(
  parameter int unsigned BLK = 255,
  localparam int unsigned CW = $clog2(BLK + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             send_i,
  input  logic             empty_i,
  input  word_t            rd_i,
  input  logic             corr_en_i,
  input  logic [CW-1:0]    corr_idx_i,
  input  logic [SYM_W-1:0] corr_mask_i,
  output logic             pop_o,
  output word_t            tx_o
);
  logic [CW-1:0]     cnt_q, cnt_nxt;
  logic [WORD_W-1:0] bad_d;
  logic              start_w;

  assign pop_o   = send_i && !empty_i;
  assign start_w = is_start(rd_i);

  ser_store_corrupt #(
    .LANES(LANES),
    .SYM_W(SYM_W),
    .BLK  (BLK)
  ) u_corrupt (
    .sym_i (rd_i.d),
    .k_i   (rd_i.k),
    .cnt_i (cnt_q),
    .en_i  (corr_en_i),
    .idx_i (corr_idx_i),
    .mask_i(corr_mask_i),
    .sym_o (bad_d),
    .cnt_o (cnt_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_o  <= IDLE_WORD;
      cnt_q <= '0;
    end else if (pop_o) begin
      if (start_w) begin
        tx_o  <= rd_i;
        cnt_q <= '0;
      end else begin
        tx_o  <= '{k: rd_i.k, d: bad_d};
        cnt_q <= cnt_nxt;
      end
    end else begin
      tx_o <= IDLE_WORD;
    end
  end
endmodule

// File: rtl/ser_store.sv
module ser_store
  import ser_store_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned BLK   = 255
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] rx_data_i,
  input  logic [1:0]  rx_k_i,
  input  logic        send_i,
  input  logic        corr_en_i,
  input  logic [7:0]  corr_idx_i,
  input  logic [7:0]  corr_mask_i,
  output logic [15:0] tx_data_o,
  output logic [1:0]  tx_k_o,
  output logic        ovf_o
);
  localparam int unsigned CW = $clog2(BLK + 1);

  word_t rx_word, wr_word, rd_word, tx_word;
  logic  push, pop, fifo_full, fifo_empty;

  assign rx_word = '{k: rx_k_i, d: rx_data_i};

  ser_store_rx u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_word),
    .full_i (fifo_full),
    .push_o (push),
    .wdata_o(wr_word),
    .ovf_o  (ovf_o)
  );

  ser_store_fifo #(
    .DEPTH(DEPTH),
    .WIDTH($bits(word_t))
  ) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .wdata_i(wr_word),
    .pop_i  (pop),
    .rdata_o(rd_word),
    .full_o (fifo_full),
    .empty_o(fifo_empty)
  );

  ser_store_tx #(
    .BLK(BLK)
  ) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .send_i     (send_i),
    .empty_i    (fifo_empty),
    .rd_i       (rd_word),
    .corr_en_i  (corr_en_i),
    .corr_idx_i (CW'(corr_idx_i)),
    .corr_mask_i(corr_mask_i),
    .pop_o      (pop),
    .tx_o       (tx_word)
  );

  assign tx_data_o = tx_word.d;
  assign tx_k_o    = tx_word.k;
endmodule

// File: rtl/ser_store_chk.sv
module ser_store_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        send_i,
  input logic        corr_en_i,
  input logic [15:0] tx_data_o,
  input logic [1:0]  tx_k_o,
  input logic        ovf_o,
  input logic        push,
  input logic        pop,
  input logic        fifo_full,
  input logic        fifo_empty,
  input logic [15:0] rd_d,
  input logic [1:0]  rd_k
);
  // R5
  idle_when_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!send_i || fifo_empty) |=> (tx_data_o == 16'hBCBC && tx_k_o == 2'b11));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  // R10
  no_push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |-> !fifo_full);

  // R3
  flags_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |=> tx_k_o == $past(rd_k));

  // R8
  ctl_lo_intact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && rd_k[0]) |=> tx_data_o[7:0] == $past(rd_d[7:0]));

  // R8
  ctl_hi_intact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && rd_k[1]) |=> tx_data_o[15:8] == $past(rd_d[15:8]));

  // R9
  plain_replay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !corr_en_i) |=> tx_data_o == $past(rd_d));
endmodule

bind ser_store ser_store_chk i_ser_store_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .send_i    (send_i),
  .corr_en_i (corr_en_i),
  .tx_data_o (tx_data_o),
  .tx_k_o    (tx_k_o),
  .ovf_o     (ovf_o),
  .push      (push),
  .pop       (pop),
  .fifo_full (fifo_full),
  .fifo_empty(fifo_empty),
  .rd_d      (rd_word.d),
  .rd_k      (rd_word.k)
);

// File: tb/test_ser_store.sv
`timescale 1ns/1ps
module test_ser_store;
  localparam logic [17:0] IDLE = {2'b11, 16'hBCBC};
  localparam logic [17:0] SOP  = {2'b01, 16'h00FB};

  // stimulus: {k, data}; commas outside and inside the packet
  localparam logic [17:0] RX_TAB [7] = '{
    IDLE, SOP, {2'b00, 16'h1234}, IDLE, {2'b00, 16'h5678},
    {2'b01, 16'h9AFD}, IDLE
  };
  localparam logic [17:0] EXP_TAB [5] = '{
    SOP, {2'b00, 16'h1234}, {2'b00, 16'h5678}, {2'b01, 16'h9AFD}, IDLE
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] rx_data = 16'hBCBC;
  logic [1:0]  rx_k = 2'b11;
  logic        send = 1'b0;
  logic        corr_en = 1'b0;
  logic [7:0]  corr_idx = 8'd0;
  logic [7:0]  corr_mask = 8'd0;
  logic [15:0] tx_data;
  logic [1:0]  tx_k;
  logic        ovf;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ser_store i_ser_store (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .rx_data_i  (rx_data),
    .rx_k_i     (rx_k),
    .send_i     (send),
    .corr_en_i  (corr_en),
    .corr_idx_i (corr_idx),
    .corr_mask_i(corr_mask),
    .tx_data_o  (tx_data),
    .tx_k_o     (tx_k),
    .ovf_o      (ovf)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [17:0] got, logic [17:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic put(logic [17:0] w);
    {rx_k, rx_data} = w;
    tick();
    {rx_k, rx_data} = IDLE;
  endtask

  task automatic replay(string tag, logic [17:0] exp);
    tick();
    chk(tag, {tx_k, tx_data}, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset out", {tx_k, tx_data}, IDLE);
    chk("R1 reset ovf", {17'd0, ovf}, 18'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: store with send low, then replay
    for (int i = 0; i < 7; i++) begin
      put(RX_TAB[i]);
      chk("R5 idle while loading", {tx_k, tx_data}, IDLE);
    end
    send = 1'b1;
    for (int i = 0; i < 5; i++) replay("R3 R4 R2 R9 replay", EXP_TAB[i]);
    send = 1'b0;

    // R6 pause and resume
    put(SOP); put({2'b00, 16'hA2A1}); put({2'b00, 16'hB2B1}); put({2'b01, 16'h00FD});
    send = 1'b1; replay("R6 first", SOP);
    send = 1'b0; replay("R6 paused", IDLE);
    send = 1'b1; replay("R6 resume", {2'b00, 16'hA2A1});
    replay("R6 next", {2'b00, 16'hB2B1});
    replay("R6 end", {2'b01, 16'h00FD});
    replay("R5 empty", IDLE);
    send = 1'b0;

    // R7 index 3 is high byte of second data word; R8 end marker byte intact
    corr_en = 1'b1; corr_idx = 8'd3; corr_mask = 8'hFF;
    put(SOP); put({2'b00, 16'h1100}); put({2'b00, 16'h3322}); put({2'b01, 16'h55FD});
    send = 1'b1;
    replay("R8 start intact", SOP);
    replay("R7 untouched", {2'b00, 16'h1100});
    replay("R7 hit idx3", {2'b00, 16'hCC22});
    replay("R8 end intact", {2'b01, 16'h55FD});
    send = 1'b0;

    // R8 control low byte skipped in count; high data byte is idx2
    corr_idx = 8'd2;
    put(SOP); put({2'b00, 16'h1100}); put({2'b01, 16'h77BC}); put({2'b01, 16'h55FD});
    send = 1'b1;
    replay("R8 start", SOP);
    replay("R8 data", {2'b00, 16'h1100});
    replay("R8 ctl kept R7 hit", {2'b01, 16'h88BC});
    replay("R8 end", {2'b01, 16'h55FD});
    send = 1'b0;

    // R7 wrap: symbols 0 and 255 both hit index 0
    corr_idx = 8'd0; corr_mask = 8'h01;
    put(SOP);
    for (int i = 0; i < 128; i++) put({2'b00, 8'(2*i+1), 8'(2*i)});
    put({2'b01, 16'h00FD});
    send = 1'b1;
    replay("R7 wrap start", SOP);
    for (int i = 0; i < 128; i++) begin
      logic [7:0] lo, hi;
      lo = 8'(2*i);   if (2*i == 0 || 2*i == 255) lo ^= 8'h01;
      hi = 8'(2*i+1); if (2*i+1 == 255) hi ^= 8'h01;
      replay("R7 wrap word", {2'b00, hi, lo});
    end
    replay("R7 wrap end", {2'b01, 16'h00FD});
    send = 1'b0; corr_en = 1'b0;
    tick();

    // R10 overflow: 256 words fit, rest dropped
    put(SOP);
    for (int i = 1; i <= 300; i++) put({2'b00, 16'(i)});
    put({2'b01, 16'h00FD});
    chk("R10 ovf set", {17'd0, ovf}, 18'd1);
    send = 1'b1;
    replay("R10 drain start", SOP);
    for (int i = 1; i < 256; i++) replay("R10 drain word", {2'b00, 16'(i)});
    replay("R10 tail dropped", IDLE);
    send = 1'b0;
    chk("R10 ovf sticky", {17'd0, ovf}, 18'd1);

    // R11 fresh packet after overflow
    put(SOP); put({2'b00, 16'hCAFE}); put({2'b01, 16'h00FD});
    send = 1'b1;
    replay("R11 start", SOP);
    replay("R11 data", {2'b00, 16'hCAFE});
    replay("R11 end", {2'b01, 16'h00FD});
    replay("R11 empty", IDLE);
    send = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule